// File: doc/BRIEF.md
# Eight-to-Five XOR Space Response Compactor

This block folds eight parallel scan-response lines into a five-bit word through a fixed XOR network. Each of the eight lines feeds exactly three of the five output bits, and no two lines share the same three outputs. Because every line feeds an odd number of outputs and all the line patterns differ, an error on any one line, on any two lines together, or on any odd number of lines in the same shift cycle always changes the compacted word. Unknown values are not masked. The caller keeps them out of the response.

Around the XOR network sits a small per-cycle comparison stage. On each accepted beat the compacted word and a tester-supplied expected word are captured together. A one-cycle mismatch pulse follows any beat whose compacted word differs from its expected word. A sticky fail flag records that at least one miscompare has happened, and it stays set until the clear input is asserted.

The response input is a valid-only stream with no back-pressure. The block accepts every beat on which `slice_valid` is high, back to back if need be. For this reason the block has no ready output, and an upstream source never has to stall.

Top module: `rsp_compactor_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `comp_word`, `comp_valid`, `mismatch` and `fail` are all zero.
- R2: Input line i is `slice_data[i-1]` and output j is `comp_word[j-1]`. The lines map to outputs as follows:
  - line 1 feeds outputs {1,2,3};
  - line 2 feeds outputs {2,3,4};
  - line 3 feeds outputs {1,3,4};
  - line 4 feeds outputs {1,2,4};
  - line 5 feeds outputs {1,4,5};
  - line 6 feeds outputs {1,3,5};
  - line 7 feeds outputs {3,4,5};
  - line 8 feeds outputs {2,4,5}.

  Each output is the XOR of the lines that feed it.
- R3: Flipping one input line flips exactly that line's three outputs, so a single error is always detected.
- R4: Flipping any two lines together flips the XOR of their two patterns, which is never zero. For example, lines 5 and 8 together flip only outputs 1 and 2.
- R5: Flipping any odd number of lines together always changes the compacted word.
- R6: On a clock edge with `slice_valid` high, `comp_word` takes the compacted value and `comp_valid` goes high for the next cycle. Without `slice_valid`, `comp_word` holds and `comp_valid` is low.
- R7: `mismatch` is high for exactly the one cycle after a valid beat whose compacted word differs from `expect_word`. It is low after matching beats and after idle cycles.
- R8: `fail` sets on the same edge that raises `mismatch` and stays set until an edge with `clear` high.
- R9: `clear` takes priority over setting `fail`. A miscompare on a beat that carries `clear` still pulses `mismatch`, but it leaves `fail` low.
- R10: The block never applies back-pressure. Valid beats on consecutive cycles each produce their own `comp_word` and `mismatch` result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_valid | input | 1 | Response beat present this cycle |
| slice_data | input | 8 | Eight scan-response lines |
| expect_word | input | 5 | Fault-free compacted word for this beat |
| clear | input | 1 | Clears the sticky fail flag |
| comp_word | output | 5 | Registered compacted word |
| comp_valid | output | 1 | comp_word was updated on the last edge |
| mismatch | output | 1 | Last beat miscompared |
| fail | output | 1 | Sticky miscompare flag |

## Verification
A wrong entry in the XOR network shows up as a wrong `comp_word` one cycle after any beat that drives the affected line. It also causes a missed or a false `mismatch` when errors are injected on that line. Injecting every error mask onto a random fault-free vector exposes any lost line or any duplicated pattern on the cycle after the beat. A broken hold, pulse or sticky register shows up as a wrong `comp_word`, `mismatch` or `fail` value within one idle or clear cycle of the beat that should have set it.

// File: rtl/rsp_cmp_pkg.sv
package rsp_cmp_pkg;
  localparam int LANES = 8;
  localparam int TAPS  = 5;
  localparam int FANOUT = 3;

  typedef logic [LANES-1:0] slice_t;
  typedef logic [TAPS-1:0]  word_t;

  // Output mask fed by each response lane; bit j means output j+1.
  function automatic word_t lane_mask(input int lane);
    case (lane)
      0:       return 5'b00111;
      1:       return 5'b01110;
      2:       return 5'b01101;
      3:       return 5'b01011;
      4:       return 5'b11001;
      5:       return 5'b10101;
      6:       return 5'b11100;
      7:       return 5'b11010;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/xor_space_net.sv
module xor_space_net
  import rsp_cmp_pkg::*;
(
  input  slice_t slice,
  output word_t  word
);
  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    logic tap_bit;
    always_comb begin
      tap_bit = 1'b0;
      for (int i = 0; i < LANES; i++) begin
        word_t m;
        m = lane_mask(i);
        if (m[j]) tap_bit = tap_bit ^ slice[i];
      end
    end
    assign word[j] = tap_bit;
  end

  // Odd fan-out means output parity tracks input parity.
  always_comb begin
    if (!$isunknown(slice)) begin
      // R5
      parity_track_chk: assert ((^word) == (^slice));
    end
  end
endmodule

// File: rtl/beat_stage.sv
module beat_stage
  import rsp_cmp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  word_t word_in,
  input  word_t expect_in,
  output logic  miss_now,
  output word_t word_out,
  output logic  valid_out,
  output logic  miss_out
);
  assign miss_now = in_valid && (word_in != expect_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out  <= '0;
      valid_out <= 1'b0;
      miss_out  <= 1'b0;
    end else begin
      valid_out <= in_valid;
      miss_out  <= miss_now;
      if (in_valid) word_out <= word_in;
    end
  end

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(word_out) && !valid_out);
  // R7
  no_miss_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !miss_out);
  // R10
  every_beat_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> valid_out && (word_out == $past(word_in)));
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
  // R8
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set && !clr |=> flag);
endmodule

// File: rtl/rsp_compactor_top.sv
module rsp_compactor_top
  import rsp_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slice_valid,
  input  logic [LANES-1:0] slice_data,
  input  logic [TAPS-1:0]  expect_word,
  input  logic             clear,
  output logic [TAPS-1:0]  comp_word,
  output logic             comp_valid,
  output logic             mismatch,
  output logic             fail
);
  word_t folded;
  logic  miss_now;

  xor_space_net u_net (
    .slice (slice_data),
    .word  (folded)
  );

  beat_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (slice_valid),
    .word_in   (folded),
    .expect_in (expect_word),
    .miss_now  (miss_now),
    .word_out  (comp_word),
    .valid_out (comp_valid),
    .miss_out  (mismatch)
  );

  sticky_flag u_fail (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (miss_now),
    .clr   (clear),
    .flag  (fail)
  );

  // R8
  miss_implies_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch && !$past(clear) |-> fail);
  // R7
  miss_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> comp_valid);
endmodule

// File: tb/test_rsp_compactor_top.sv
module test_rsp_compactor_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       slice_valid;
  logic [7:0] slice_data;
  logic [4:0] expect_word;
  logic       clear;
  logic [4:0] comp_word;
  logic       comp_valid;
  logic       mismatch;
  logic       fail;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  rsp_compactor_top i_rsp_compactor_top (
    .clk(clk), .rst_n(rst_n), .slice_valid(slice_valid), .slice_data(slice_data),
    .expect_word(expect_word), .clear(clear), .comp_word(comp_word),
    .comp_valid(comp_valid), .mismatch(mismatch), .fail(fail)
  );

  function automatic logic [4:0] out_bits(input int a, input int b, input int c);
    return 5'((1 << (a-1)) | (1 << (b-1)) | (1 << (c-1)));
  endfunction

  function automatic logic [4:0] ref_pat(input int lane);
    case (lane)
      0: return out_bits(1, 2, 3);
      1: return out_bits(2, 3, 4);
      2: return out_bits(1, 3, 4);
      3: return out_bits(1, 2, 4);
      4: return out_bits(1, 4, 5);
      5: return out_bits(1, 3, 5);
      6: return out_bits(3, 4, 5);
      default: return out_bits(2, 4, 5);
    endcase
  endfunction

  function automatic logic [4:0] model(input logic [7:0] d);
    logic [4:0] w = '0;
    for (int i = 0; i < 8; i++) if (d[i]) w = w ^ ref_pat(i);
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] d, input logic [4:0] e, input logic c);
    @(negedge clk);
    slice_valid = 1'b1; slice_data = d; expect_word = e; clear = c;
    @(posedge clk); #1;
  endtask

  task automatic idle(input logic c);
    @(negedge clk);
    slice_valid = 1'b0; slice_data = $urandom; expect_word = $urandom; clear = c;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [4:0] g;
    logic [4:0] held;
    int seed_val;
    seed_val = $urandom(32'd2718);
    rst_n = 1'b0; slice_valid = 1'b0; slice_data = '0; expect_word = '0; clear = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 word in reset", 32'(comp_word), 0);
    chk("R1 fail in reset", 32'(fail), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 word", 32'(comp_word), 0);
    chk("R1 valid", 32'(comp_valid), 0);
    chk("R1 mismatch", 32'(mismatch), 0);
    chk("R1 fail", 32'(fail), 0);

    // R2: each lane alone gives its own mask
    for (int i = 0; i < 8; i++) begin
      beat(8'(1 << i), ref_pat(i), 1'b0);
      chk("R2 lane mask", 32'(comp_word), 32'(ref_pat(i)));
      chk("R2 no miscompare", 32'(mismatch), 0);
    end
    beat(8'hFF, 5'b00000, 1'b0);
    chk("R2 all lanes", 32'(comp_word), 32'(model(8'hFF)));

    // R6 hold while idle, R7 no pulse while idle
    held = comp_word;
    for (int k = 0; k < 3; k++) begin
      idle(1'b0);
      chk("R6 hold", 32'(comp_word), 32'(held));
      chk("R6 valid low", 32'(comp_valid), 0);
      chk("R7 idle mismatch", 32'(mismatch), 0);
    end
    idle(1'b1);
    chk("R8 clear", 32'(fail), 0);

    // R3 R4 R5: every error mask on two random fault-free vectors
    for (int rep = 0; rep < 2; rep++) begin
      v = 8'($urandom);
      g = model(v);
      beat(v, g, 1'b0);
      chk("R7 fault-free", 32'(mismatch), 0);
      chk("R8 fail stays low", 32'(fail), 0);
      for (int m = 1; m < 256; m++) begin
        int cnt;
        cnt = $countones(m);
        beat(v ^ 8'(m), g, 1'b0);
        chk("R3 R4 R5 error footprint", 32'(comp_word ^ g), 32'(model(8'(m))));
        if (cnt == 1) chk("R3 single detected", 32'(mismatch), 1);
        else if (cnt == 2) chk("R4 double detected", 32'(mismatch), 1);
        else if (cnt % 2 == 1) chk("R5 odd detected", 32'(mismatch), 1);
      end
      chk("R8 fail set", 32'(fail), 1);
      idle(1'b0);
      chk("R8 fail sticky", 32'(fail), 1);
      chk("R7 pulse ends", 32'(mismatch), 0);
      idle(1'b1);
      chk("R8 fail cleared", 32'(fail), 0);
    end

    // R4 example: lanes 5 and 8 flip outputs 1 and 2 only
    beat(8'b1001_0000, 5'b00000, 1'b0);
    chk("R4 lanes 5 and 8", 32'(comp_word), 32'h03);

    // R9 clear beats a same-cycle miscompare
    idle(1'b1);
    v = 8'h5A; g = model(v);
    beat(v, g ^ 5'h04, 1'b1);
    chk("R9 mismatch pulses", 32'(mismatch), 1);
    chk("R9 fail held low", 32'(fail), 0);
    beat(v, g ^ 5'h04, 1'b0);
    chk("R8 fail sets", 32'(fail), 1);
    idle(1'b1);

    // R10 back-to-back and random traffic
    for (int k = 0; k < 300; k++) begin
      logic bad;
      v = 8'($urandom);
      bad = 1'($urandom);
      g = model(v);
      beat(v, bad ? (g ^ 5'(($urandom % 31) + 1)) : g, 1'b0);
      chk("R10 word", 32'(comp_word), 32'(g));
      chk("R10 valid", 32'(comp_valid), 1);
      chk("R7 mismatch", 32'(mismatch), 32'(bad));
      if (($urandom % 4) == 0) begin
        idle(1'b0);
        chk("R6 hold random", 32'(comp_word), 32'(g));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule